// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block resolves the flag-conditioned relative branches of an 8-bit processor core. The decoder supplies a 3-bit condition code. The flag register supplies the carry, zero, negative and overflow bits. The fetch stage supplies the program counter, already advanced past the offset byte, and the signed 8-bit displacement. From these, the unit decides in the same cycle whether the branch is taken. It also returns the program counter the core should continue from and the number of cycles the instruction costs.

The cycle cost depends on two things: whether the branch is taken, and, for a taken branch, whether the destination lies in a different 256-byte page from the fall-through address. When the core pulses a start strobe, the unit loads that cost into a down-counter. It then holds a busy output so the core stalls for the remaining cycles of the instruction.

Top module: `rel_branch_unit`

## Requirements
- R1: The condition code is {flag select[1:0], expected value}. Flag select 0 picks negative, 1 picks overflow, 2 picks carry and 3 picks zero. The branch is taken (`taken_o`=1) exactly when the selected flag equals the expected-value bit.
- R2: When the branch is not taken, `next_pc_o` equals `pc_i` and `cycles_o` is 2.
- R3: When the branch is taken, `next_pc_o` equals `pc_i` plus the sign-extended offset, modulo 65536.
- R4: A taken branch whose target has the same upper byte as `pc_i` reports `cycles_o` = 3.
- R5: A taken branch whose target upper byte differs from that of `pc_i` reports `cycles_o` = 5.
- R6: The offset is 8-bit two's complement: 0x80 moves back by 128, 0x7F moves forward by 127, and the sum wraps across 0xFFFF/0x0000.
- R7: A `start_i` pulse accepted while idle loads `cycles_o` into the counter. `busy_o` is then high for `cycles_o`-1 clock cycles after that edge and low afterwards.
- R8: A `start_i` pulse that arrives while `busy_o` is high is ignored, and the countdown in progress continues unchanged.
- R9: After reset, `busy_o` is low until the first accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the stall countdown for the current branch |
| cond_sel_i | input | 3 | Condition code {flag select, expected value} |
| flag_c_i | input | 1 | Carry flag |
| flag_z_i | input | 1 | Zero flag |
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Overflow flag |
| pc_i | input | PC_W (16) | Program counter past the offset byte |
| offset_i | input | OFS_W (8) | Signed displacement |
| taken_o | output | 1 | Branch condition is met |
| next_pc_o | output | PC_W (16) | Program counter to continue from |
| cycles_o | output | CNT_W (3) | Cycles used by this branch |
| busy_o | output | 1 | Core must stall |

## Verification
The assertions assume that `start_i` and the branch inputs are stable around the clock edge. They also assume that the cycle cost loaded on an accepted start is the one shown on `cycles_o` in that same cycle. The bench meets these assumptions by changing every input only on the falling clock edge. It holds each set of inputs for a whole cycle and issues starts both while idle and in the middle of a countdown. Beyond the directed cases (every condition code, both offset extremes, page crossings in both directions and address wraparound), it sends random flags, program counters and offsets through a behavioural model that is compared on every clock.

// File: rtl/rbu_pkg.sv
package rbu_pkg;

  typedef enum logic [1:0] {
    FS_NEG   = 2'd0,
    FS_OVF   = 2'd1,
    FS_CARRY = 2'd2,
    FS_ZERO  = 2'd3
  } flag_sel_e;

  // Selected flag compared with the expected-value bit of the code.
  function automatic logic cond_met(input logic [2:0] code,
                                    input logic n, input logic v,
                                    input logic c, input logic z);
    logic f;
    case (flag_sel_e'(code[2:1]))
      FS_NEG:   f = n;
      FS_OVF:   f = v;
      FS_CARRY: f = c;
      default:  f = z;
    endcase
    return f == code[0];
  endfunction

endpackage

// File: rtl/rbu_cond_eval.sv
module rbu_cond_eval
  import rbu_pkg::*;
(
  input  logic [2:0] cond_sel_i,
  input  logic       flag_c_i,
  input  logic       flag_z_i,
  input  logic       flag_n_i,
  input  logic       flag_v_i,
  output logic       taken_o
);
  always_comb taken_o = cond_met(cond_sel_i, flag_n_i, flag_v_i, flag_c_i, flag_z_i);
endmodule

// File: rtl/rbu_target_calc.sv
module rbu_target_calc #(
  parameter int PC_W      = 16,
  parameter int OFS_W     = 8,
  parameter int PAGE_BITS = 8
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFS_W-1:0] offset_i,
  output logic [PC_W-1:0]  target_o,
  output logic             page_cross_o
);
  localparam int EXT_W = PC_W - OFS_W;

  function automatic logic [PC_W-1:0] add_rel(input logic [PC_W-1:0] base,
                                              input logic [OFS_W-1:0] ofs);
    return base + {{EXT_W{ofs[OFS_W-1]}}, ofs};
  endfunction

  function automatic logic other_page(input logic [PC_W-1:0] a,
                                      input logic [PC_W-1:0] b);
    return a[PC_W-1:PAGE_BITS] != b[PC_W-1:PAGE_BITS];
  endfunction

  always_comb begin
    target_o     = add_rel(pc_i, offset_i);
    page_cross_o = other_page(target_o, pc_i);
  end
endmodule

// File: rtl/rbu_stall_ctr.sv
module rbu_stall_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_comb busy_o = cnt_q > CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (start_i && !busy_o) cnt_q <= load_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit #(
  parameter int PC_W      = 16,
  parameter int OFS_W     = 8,
  parameter int PAGE_BITS = 8,
  parameter int CYC_BASE  = 2,
  parameter int CYC_TAKEN = 1,
  parameter int CYC_PAGE  = 2,
  parameter int CNT_W     = $clog2(CYC_BASE + CYC_TAKEN + CYC_PAGE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       cond_sel_i,
  input  logic             flag_c_i,
  input  logic             flag_z_i,
  input  logic             flag_n_i,
  input  logic             flag_v_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFS_W-1:0] offset_i,
  output logic             taken_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic [CNT_W-1:0] cycles_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] C_NOT  = CNT_W'(CYC_BASE);
  localparam logic [CNT_W-1:0] C_SAME = CNT_W'(CYC_BASE + CYC_TAKEN);
  localparam logic [CNT_W-1:0] C_FAR  = CNT_W'(CYC_BASE + CYC_TAKEN + CYC_PAGE);

  // Named internal events for the checker
  logic             taken_w;
  logic             page_cross_w;
  logic [PC_W-1:0]  target_w;
  logic [CNT_W-1:0] cnt_q;

  rbu_cond_eval i_cond (
    .cond_sel_i (cond_sel_i),
    .flag_c_i   (flag_c_i),
    .flag_z_i   (flag_z_i),
    .flag_n_i   (flag_n_i),
    .flag_v_i   (flag_v_i),
    .taken_o    (taken_w)
  );

  rbu_target_calc #(.PC_W(PC_W), .OFS_W(OFS_W), .PAGE_BITS(PAGE_BITS)) i_tgt (
    .pc_i         (pc_i),
    .offset_i     (offset_i),
    .target_o     (target_w),
    .page_cross_o (page_cross_w)
  );

  always_comb begin
    taken_o   = taken_w;
    next_pc_o = taken_w ? target_w : pc_i;
    if (!taken_w)          cycles_o = C_NOT;
    else if (page_cross_w) cycles_o = C_FAR;
    else                   cycles_o = C_SAME;
  end

  rbu_stall_ctr #(.CNT_W(CNT_W)) i_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_i  (cycles_o),
    .cnt_o   (cnt_q),
    .busy_o  (busy_o)
  );
endmodule

// File: rtl/rbu_checker.sv
module rbu_checker #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [PC_W-1:0]  pc_i,
  input logic             taken_w,
  input logic             page_cross_w,
  input logic [PC_W-1:0]  next_pc_o,
  input logic [CNT_W-1:0] cycles_o,
  input logic             busy_o,
  input logic [CNT_W-1:0] cnt_q
);
  // R2: fall-through keeps the program counter and costs two cycles
  p_fallthrough_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_w |-> (next_pc_o == pc_i && cycles_o == CNT_W'(2)));

  // R4: taken within the page costs three cycles
  p_same_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_w && !page_cross_w) |-> cycles_o == CNT_W'(3));

  // R5: taken across a page costs five cycles
  p_far_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_w && page_cross_w) |-> cycles_o == CNT_W'(5));

  // R7: an accepted start loads the cost shown in that cycle
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (cnt_q == $past(cycles_o) && busy_o));

  // R8: a start during a stall does not restart the countdown
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R9: busy only rises from an accepted start
  p_busy_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind rel_branch_unit rbu_checker #(.PC_W(PC_W), .CNT_W(CNT_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .pc_i         (pc_i),
  .taken_w      (taken_w),
  .page_cross_w (page_cross_w),
  .next_pc_o    (next_pc_o),
  .cycles_o     (cycles_o),
  .busy_o       (busy_o),
  .cnt_q        (cnt_q)
);

// File: tb/test_rel_branch_unit.sv
module test_rel_branch_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  cond_sel_i = '0;
  logic        flag_c_i = 1'b0, flag_z_i = 1'b0, flag_n_i = 1'b0, flag_v_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [7:0]  offset_i = '0;
  logic        taken_o;
  logic [15:0] next_pc_o;
  logic [2:0]  cycles_o;
  logic        busy_o;

  int total = 0;
  int bad = 0;
  int ref_cnt = 0;
  string busy_tag = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  rel_branch_unit i_rel_branch_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cond_sel_i(cond_sel_i),
    .flag_c_i(flag_c_i), .flag_z_i(flag_z_i), .flag_n_i(flag_n_i), .flag_v_i(flag_v_i),
    .pc_i(pc_i), .offset_i(offset_i), .taken_o(taken_o), .next_pc_o(next_pc_o),
    .cycles_o(cycles_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One clock of stimulus; nvcz = {n, v, c, z}
  task automatic step(input bit st, input logic [2:0] sel, input logic [3:0] nvcz,
                      input logic [15:0] pc, input logic [7:0] ofs, input string pc_tag);
    int flags[4];
    int disp, tgt, exp_cyc;
    bit exp_take;
    @(negedge clk);
    check(busy_o == (ref_cnt > 1), busy_tag, busy_o, ref_cnt > 1);
    start_i = st; cond_sel_i = sel; pc_i = pc; offset_i = ofs;
    {flag_n_i, flag_v_i, flag_c_i, flag_z_i} = nvcz;
    #1;
    flags[0] = nvcz[3]; flags[1] = nvcz[2]; flags[2] = nvcz[1]; flags[3] = nvcz[0];
    exp_take = (flags[sel / 2] == (sel % 2));
    disp = (ofs >= 128) ? int'(ofs) - 256 : int'(ofs);
    tgt = (int'(pc) + disp + 65536) % 65536;
    if (!exp_take)                 exp_cyc = 2;
    else if ((tgt / 256) != (pc / 256)) exp_cyc = 5;
    else                           exp_cyc = 3;
    check(taken_o == exp_take, "R1", taken_o, exp_take);
    if (exp_take) check(next_pc_o == tgt[15:0], pc_tag, next_pc_o, tgt);
    else          check(next_pc_o == pc, "R2", next_pc_o, pc);
    check(cycles_o == exp_cyc, exp_cyc == 2 ? "R2" : (exp_cyc == 3 ? "R4" : "R5"),
          cycles_o, exp_cyc);
    @(posedge clk);
    if (st && ref_cnt <= 1) begin ref_cnt = exp_cyc; busy_tag = "R7"; end
    else begin
      if (st) busy_tag = "R8";
      if (ref_cnt > 0) ref_cnt--;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(busy_o == 1'b0, "R9", busy_o, 0);
    @(negedge clk) rst_n = 1'b1;
    // R1: every condition code against flags all-set and all-clear
    for (int s = 0; s < 8; s++) begin
      step(0, 3'(s), 4'hF, 16'h1234, 8'h10, "R3");
      step(0, 3'(s), 4'h0, 16'h1234, 8'h10, "R3");
    end
    // R6: offset extremes and wraparound; R5 crossings both ways
    step(0, 3'd1, 4'h8, 16'h1280, 8'h80, "R6");
    step(0, 3'd1, 4'h8, 16'h1200, 8'h80, "R6");
    step(0, 3'd1, 4'h8, 16'h1280, 8'h7F, "R6");
    step(0, 3'd1, 4'h8, 16'h1281, 8'h7F, "R6");
    step(0, 3'd1, 4'h8, 16'hFFF0, 8'h20, "R6");
    step(0, 3'd1, 4'h8, 16'h0005, 8'hF0, "R6");
    // R7: countdown for each cost; R8: starts during a stall
    step(1, 3'd0, 4'h8, 16'h2000, 8'h04, "R3");
    repeat (3) step(0, 3'd0, 4'h0, 16'h2000, 8'h04, "R3");
    step(1, 3'd1, 4'h8, 16'h20F0, 8'h40, "R3");
    repeat (2) step(1, 3'd0, 4'h8, 16'h2000, 8'h01, "R3");
    repeat (4) step(0, 3'd0, 4'h0, 16'h2000, 8'h01, "R3");
    step(1, 3'd1, 4'h8, 16'h3000, 8'h01, "R3");
    repeat (3) step(0, 3'd0, 4'h0, 16'h2000, 8'h01, "R3");
    // Random traffic against the reference model
    for (int i = 0; i < 600; i++)
      step(($urandom % 3) == 0, 3'($urandom), 4'($urandom), 16'($urandom),
           8'($urandom), "R3");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule